// File: doc/BRIEF.md
# Framed Parallel-to-Serial Word Transmitter

This block turns a stream of 24-bit parallel words into a continuous serial line made of 26-bit frames. A frame carries the 24 data bits, least significant bit first, and then two fixed boundary bits, a one followed by a zero. Frames follow each other with no gap. One frame goes out per reference word period, so the serial bit clock runs 26 times faster than the word rate. Everything runs on that bit clock.

Words come in with a strobe that may be slower than the frame rate. The strobe passes through a two-flop synchronizer, and its rising edge loads the word into a holding register and raises a pending flag. At the last bit of every frame the pending word, or all zeros if nothing is pending, moves into the shift register for the next frame. Transmission and capture only run when the lock input and the transmit-direction input are both high. While the block is inactive the line is driven low and the bit-clock enable is low. The word-clock output follows the direction input.

The `word_i` input must be held stable from the strobe's rising edge until three bit-clock edges later, when it is sampled.

Top module: `frame_serializer`

## Requirements
- R1: While active, `ser_o` carries back-to-back 26-bit frames. At frame position k (0..23) it carries bit k of the word, position 24 is the boundary bit 1 and position 25 is the boundary bit 0.
- R2: A rising edge of `strobe_i` is captured at the third bit-clock edge after it. If that edge comes no later than the end of frame position 24, the captured word is sent in the next frame.
- R3: A frame for which no word is pending carries 24 zero data bits and still carries the boundary bits 1 and 0.
- R4: A strobe edge that arrives while the block is inactive (`lock_i` low or `tx_dir_i` low) is ignored, and the pending flag is cleared while inactive.
- R5: When a capture falls on the same edge as the frame load (a strobe rising at frame position 23), the previously pending word goes into the next frame and the new word goes into the frame after that.
- R6: When two words are captured within one frame, only the later one is sent, and the frame after it is empty.
- R7: `wclk_o` is high while `tx_dir_i` is high and low while it is low.
- R8: While inactive, `ser_o` and `bclk_en_o` are 0. While active, `bclk_en_o` is 1.
- R9: Reset, or any inactive cycle, sets the bit position to 0 and clears the shift register. The first active cycle therefore starts an empty frame at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Active-low reset |
| lock_i | input | 1 | Clock-lock indication, high when the bit clock is stable |
| tx_dir_i | input | 1 | Direction select, high for transmit |
| strobe_i | input | 1 | Word strobe, asynchronous, rising edge captures |
| word_i | input | 24 | Parallel data word |
| ser_o | output | 1 | Serial data out |
| bclk_en_o | output | 1 | Forwarded bit-clock enable |
| wclk_o | output | 1 | Word clock output, high in transmit direction |

## Verification
The two functions that can land on one clock edge are a strobe capture and the frame load, which empties the pending flag. The bench provokes this by raising the strobe at frame position 23, so that the capture lands exactly on the load edge of position 25. The collision is judged correct when the next frame carries the earlier word and the frame after it carries the new one. A second case puts two captures in one frame with no load between them and checks that only the later word appears.

// File: rtl/fser_pkg.sv
package fser_pkg;

  // Number of fixed boundary bits appended after the data bits of a frame.
  localparam int unsigned BOUND_BITS = 2;

  // Next bit position: counts up and wraps to 0 after the last position.
  function automatic int unsigned wrap_inc(int unsigned pos, int unsigned last);
    return (pos >= last) ? 0 : pos + 1;
  endfunction

  // Level of a boundary bit: the first bit after the data is 1, the second is 0.
  function automatic logic bnd_level(int unsigned pos, int unsigned data_w);
    return (pos == data_w);
  endfunction

endpackage

// File: rtl/fser_slot_counter.sv
module fser_slot_counter #(
  parameter int unsigned FRAME_W = 26,
  localparam int unsigned CNT_W  = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             frame_end_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (!run_i) pos_q <= '0;
    else             pos_q <= CNT_W'(fser_pkg::wrap_inc(32'(pos_q), FRAME_W - 1));
  end

  assign pos_o       = pos_q;
  assign frame_end_o = run_i && (pos_q == LAST_POS);

  // R1
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && pos_q != LAST_POS) |=> (!run_i || pos_q == $past(pos_q) + 1'b1));

endmodule

// File: rtl/fser_capture.sv
module fser_capture #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              pend_o
);
  logic [SYNC_N:0]    sync_q;
  logic [DATA_W-1:0]  hold_q;
  logic               pend_q;
  logic               rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_N-1:0], strobe_i};
  end

  assign rise = run_i && sync_q[SYNC_N-1] && !sync_q[SYNC_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      pend_q <= 1'b0;
    end else if (!run_i) begin
      pend_q <= 1'b0;
    end else if (rise) begin
      hold_q <= word_i;
      pend_q <= 1'b1;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end

  assign hold_o = hold_q;
  assign pend_o = pend_q;

  // R2
  cap_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (pend_q && hold_q == $past(word_i)));

  // R4
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pend_q);

  // R5
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && take_i) |=> pend_q);

endmodule

// File: rtl/fser_shifter.sv
module fser_shifter #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              load_i,
  input  logic              pend_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic              ser_o
);
  localparam logic [CNT_W-1:0] DATA_POS = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic              in_data;

  assign in_data = (pos_i < DATA_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (!run_i)  sh_q <= '0;
    else if (load_i)  sh_q <= pend_i ? hold_i : '0;
    else if (in_data) sh_q <= sh_q >> 1;
  end

  always_comb begin
    if (!run_i)       ser_o = 1'b0;
    else if (in_data) ser_o = sh_q[0];
    else              ser_o = fser_pkg::bnd_level(32'(pos_i), DATA_W);
  end

  // R3
  empty_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !pend_i) |=> (sh_q == '0));

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer #(
  parameter int unsigned DATA_W = 24,
  parameter int unsigned SYNC_N = 2,
  localparam int unsigned FRAME_W = DATA_W + fser_pkg::BOUND_BITS,
  localparam int unsigned CNT_W   = $clog2(FRAME_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_i,
  input  logic              tx_dir_i,
  input  logic              strobe_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              ser_o,
  output logic              bclk_en_o,
  output logic              wclk_o
);
  logic              active;
  logic [CNT_W-1:0]  pos;
  logic              frame_end;
  logic [DATA_W-1:0] hold;
  logic              pend;

  assign active = lock_i && tx_dir_i;

  fser_slot_counter #(.FRAME_W(FRAME_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_i(active),
    .pos_o(pos), .frame_end_o(frame_end)
  );

  fser_capture #(.DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_cap (
    .clk(clk), .rst_n(rst_n), .run_i(active), .strobe_i(strobe_i),
    .word_i(word_i), .take_i(frame_end), .hold_o(hold), .pend_o(pend)
  );

  fser_shifter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .run_i(active), .load_i(frame_end),
    .pend_i(pend), .hold_i(hold), .pos_i(pos), .ser_o(ser_o)
  );

  assign bclk_en_o = active;
  assign wclk_o    = tx_dir_i;

  // R8
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_i || !tx_dir_i) |-> (!ser_o && !bclk_en_o));

endmodule

// File: tb/frame_serializer_bench.sv
module frame_serializer_bench;
  localparam int CLK_P = 10;
  localparam int NONE  = 99;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lock_i = 1'b0;
  logic        tx_dir_i = 1'b1;
  logic        strobe_i = 1'b0;
  logic [23:0] word_i = '0;
  logic        ser_o, bclk_en_o, wclk_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  frame_serializer u_frame_serializer (
    .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .tx_dir_i(tx_dir_i),
    .strobe_i(strobe_i), .word_i(word_i), .ser_o(ser_o),
    .bclk_en_o(bclk_en_o), .wclk_o(wclk_o)
  );

  // word, strobe position within the frame (NONE = no strobe)
  typedef struct packed { logic [23:0] w; int pos; } vec_t;
  localparam vec_t VECS [8] = '{
    '{24'hA5C3F1, 4},  '{24'h000001, 0},  '{24'h800000, 22},
    '{24'h123456, NONE}, '{24'hFFFFFF, 10}, '{24'h5A5A5A, 17},
    '{24'h000000, 2},  '{24'hC0FFEE, NONE}
  };

  function automatic logic [25:0] exp_frame(logic [23:0] w, bit valid);
    return {1'b0, 1'b1, (valid ? w : 24'h0)};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // One frame of 26 bit times; up to two strobe pulses; optional activation at t=0.
  task automatic run_frame(input bit arm,
                           input int pa, input logic [23:0] wa,
                           input int pb, input logic [23:0] wb,
                           output logic [25:0] got);
    for (int t = 0; t < 26; t++) begin
      @(negedge clk);
      if (arm && t == 0) begin lock_i = 1'b1; tx_dir_i = 1'b1; end
      if (t == pa) begin word_i = wa; strobe_i = 1'b1; end
      if (t == pa + 2) strobe_i = 1'b0;
      if (t == pb) begin word_i = wb; strobe_i = 1'b1; end
      if (t == pb + 2) strobe_i = 1'b0;
      #(CLK_P/4);
      got[t] = ser_o;
      if (t == 5) chk(bclk_en_o == 1'b1, "R8 bclk_en active", 32'(bclk_en_o), 1);
    end
  endtask

  task automatic pulse_idle(input logic [23:0] w);
    @(negedge clk); word_i = w; strobe_i = 1'b1;
    repeat (3) @(negedge clk);
    strobe_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [25:0] got;
    logic [23:0] prev_w;
    bit          prev_v;

    repeat (3) @(negedge clk);
    #(CLK_P/4);
    // R9 reset state
    chk(ser_o == 1'b0, "R9 reset ser_o", 32'(ser_o), 0);
    chk(bclk_en_o == 1'b0, "R8 reset bclk_en", 32'(bclk_en_o), 0);
    chk(wclk_o == 1'b1, "R7 wclk high in transmit", 32'(wclk_o), 1);
    @(negedge clk); rst_n = 1'b1;

    // R4: strobe before lock is ignored
    pulse_idle(24'hDEAD01);
    chk(ser_o == 1'b0, "R8 idle line low", 32'(ser_o), 0);
    run_frame(1'b1, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R9 first frame empty", 32'(got), 32'(exp_frame(0, 0)));
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R4 pre-lock word ignored", 32'(got), 32'(exp_frame(0, 0)));

    // R1 R2 R3: table walk, frame i carries word captured during frame i-1
    prev_w = '0; prev_v = 1'b0;
    foreach (VECS[i]) begin
      run_frame(1'b0, VECS[i].pos, VECS[i].w, NONE, 0, got);
      chk(got == exp_frame(prev_w, prev_v), prev_v ? "R1 R2 data frame" : "R3 empty frame",
          32'(got), 32'(exp_frame(prev_w, prev_v)));
      prev_w = VECS[i].w; prev_v = (VECS[i].pos != NONE);
    end
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(prev_w, prev_v), "R3 trailing frame", 32'(got), 32'(exp_frame(prev_w, prev_v)));

    // R5: capture on the load edge
    run_frame(1'b0, 5, 24'h111AAA, 23, 24'h222BBB, got);
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(24'h111AAA, 1), "R5 earlier word first", 32'(got), 32'(exp_frame(24'h111AAA, 1)));
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(24'h222BBB, 1), "R5 colliding word next", 32'(got), 32'(exp_frame(24'h222BBB, 1)));

    // R6: two captures in one frame
    run_frame(1'b0, 3, 24'h0F0F0F, 12, 24'h00BEEF, got);
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(24'h00BEEF, 1), "R6 latest word wins", 32'(got), 32'(exp_frame(24'h00BEEF, 1)));
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R6 no second copy", 32'(got), 32'(exp_frame(0, 0)));

    // R7 R8: direction low
    @(negedge clk); tx_dir_i = 1'b0; #(CLK_P/4);
    chk(wclk_o == 1'b0, "R7 wclk low in receive", 32'(wclk_o), 0);
    chk(ser_o == 1'b0 && bclk_en_o == 1'b0, "R8 dir low idle", {30'd0, ser_o, bclk_en_o}, 0);
    // R4: strobe while direction low is ignored
    pulse_idle(24'h777777);
    run_frame(1'b1, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R9 restart frame empty", 32'(got), 32'(exp_frame(0, 0)));
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R4 dir-low word ignored", 32'(got), 32'(exp_frame(0, 0)));

    // R9: drop lock with a word pending, then restart
    run_frame(1'b0, 4, 24'h3C3C3C, NONE, 0, got);
    @(negedge clk); lock_i = 1'b0; #(CLK_P/4);
    chk(ser_o == 1'b0 && wclk_o == 1'b1, "R8 lock low idle", {30'd0, ser_o, wclk_o}, 1);
    repeat (2) @(negedge clk);
    run_frame(1'b1, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R9 lock restart empty", 32'(got), 32'(exp_frame(0, 0)));
    run_frame(1'b0, NONE, 0, NONE, 0, got);
    chk(got == exp_frame(0, 0), "R4 pending cleared on lock loss", 32'(got), 32'(exp_frame(0, 0)));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule